// File: doc/BRIEF.md
# Trap-Return Status Update Unit

This unit carries out the three ways a hart leaves a trap handler: the supervisor return, the machine return and the return from a resumable non-maskable interrupt. For one request it takes the current privilege level and virtualization state, the status, hypervisor-status and NMI-status words, and the three saved return addresses. From these it decides whether the return is allowed. If it is, the unit produces the updated status words, the privilege level and virtualization state to resume in, and the address to resume at. If it is not, it produces a fault code.

Configuration inputs select which optional features are present: compressed instructions, user mode, the hypervisor, supervisor and machine double-trap tracking, and physical memory protection with no rules programmed. A request is given in one cycle. The result is registered and appears, with `done` high, in the next cycle. The surrounding pipeline writes the returned words back into its own architectural registers.

Top module: `trap_return_unit`

Privilege encoding: 0 = user, 1 = supervisor, 3 = machine. Return kind: 0 = supervisor return, 1 = machine return, 2 = NMI return, 3 = reserved. Status word bits: 0 SIE, 1 MIE, 2 SPIE, 3 MPIE, 4 SPP, 6:5 MPP, 7 MPV, 8 MPRV, 9 SDT, 10 MDT, 11 TSR. Hypervisor-status bits: 0 SPV, 1 VTSR. NMI-status bits: 0 NMIE, 1 NPV, 3:2 NPP. Bits not named here pass through unchanged.

## Requirements
- R1: A supervisor return raises illegal (code 2) if the privilege is user, or if TSR is set and the privilege is not machine. Otherwise, if virtualized with VTSR set, it raises virtual-instruction (code 22). Return kind 3 always raises illegal.
- R2: When compressed support is off and bit 0 or bit 1 of the selected return address is set, the return raises misaligned (code 0). Misaligned is checked after the privilege test and before the TSR, VTSR and protection tests.
- R3: A supervisor return copies SPIE into SIE, sets SPIE, clears SPP and MPRV, resumes at the supervisor return address, and enters the privilege held in SPP.
- R4: A supervisor return with the hypervisor present and virtualization off takes its new virtualization state from SPV and clears SPV. Otherwise virtualization and SPV are left as they were.
- R5: A machine return copies MPIE into MIE, sets MPIE, writes MPP with user (0) if user mode exists and machine (3) if not, clears MPV, resumes at the machine return address, and enters the privilege held in MPP.
- R6: A machine return clears MPRV only when the target privilege is not machine. Its new virtualization state is MPV when the target is not machine, and 0 otherwise.
- R7: An NMI return enters the privilege in NPP and the virtualization in NPV (forced to 0 when NPP is machine), sets NMIE, and resumes at the NMI return address. It clears MPRV only when the target is below machine. It changes no other status bit except under R9.
- R8: A machine or NMI return raises illegal (code 2) unless the privilege is machine. If protection is enabled with zero rules and the target is not machine, it raises access fault (code 1).
- R9: With supervisor double-trap support, a machine or NMI return to user, VS or VU clears SDT, and a return to VU also clears the virtual-supervisor SDT. A supervisor return always clears SDT, and clears the virtual-supervisor SDT only when going from HS to VU. With machine double-trap support, a machine return clears MDT, an NMI return to below machine clears MDT, and a supervisor return executed in machine mode clears MDT.
- R10: On a fault, `done` and `fault` rise together with the code, and every other output keeps its previous value.
- R11: `done` is high exactly in the cycle after an accepted request. After reset the outputs hold privilege 3, virtualization 0, zero status words, zero address and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Return kind (0 S, 1 M, 2 NMI, 3 reserved) |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization state |
| st_in | input | 12 | Status word |
| hst_in | input | 4 | Hypervisor-status word |
| nst_in | input | 4 | NMI-status word |
| vs_sdt_in | input | 1 | Virtual-supervisor SDT bit |
| sepc_in | input | XLEN | Supervisor return address |
| mepc_in | input | XLEN | Machine return address |
| nepc_in | input | XLEN | NMI return address |
| cfg_cmp | input | 1 | Compressed instructions present |
| cfg_umode | input | 1 | User mode present |
| cfg_hyp | input | 1 | Hypervisor present |
| cfg_sdbl | input | 1 | Supervisor double-trap tracking |
| cfg_mdbl | input | 1 | Machine double-trap tracking |
| cfg_pmp_on | input | 1 | Memory protection enabled |
| cfg_pmp_empty | input | 1 | Memory protection has zero rules |
| done | output | 1 | Result valid |
| fault | output | 1 | Return refused |
| fault_code | output | 5 | Fault cause (0, 1, 2, 22) |
| st_out | output | 12 | Updated status word |
| hst_out | output | 4 | Updated hypervisor-status word |
| nst_out | output | 4 | Updated NMI-status word |
| vs_sdt_out | output | 1 | Updated virtual-supervisor SDT |
| new_priv | output | 2 | Privilege to resume in |
| new_virt | output | 1 | Virtualization to resume in |
| ret_pc | output | XLEN | Address to resume at |

## Verification
The checker watches four properties on every cycle. It checks that `done` follows only a request. It checks that a refused return leaves every output word and the privilege exactly as they were. It checks that the fault code is always one of the four legal values and that misaligned appears only when compressed support was off. It also checks the invariant bits each kind must leave behind: SPIE set and SPP cleared, MPIE set and MPV cleared, NMIE set. The directed scenarios show what depends on specific operand values and cannot be written as a general property: the order in which the fault checks win, conditional MPRV and MDT clearing, the choice of virtualization source, and the VU-only clearing of the virtual-supervisor SDT.

// File: rtl/tret_pkg.sv
`timescale 1ns/1ps
package tret_pkg;
  localparam int ST_W  = 12;
  localparam int HST_W = 4;
  localparam int NST_W = 4;
  localparam int FC_W  = 5;

  localparam logic [1:0] LVL_USER = 2'd0;
  localparam logic [1:0] LVL_SUPV = 2'd1;
  localparam logic [1:0] LVL_MACH = 2'd3;

  localparam logic [1:0] RK_SRET = 2'd0;
  localparam logic [1:0] RK_MRET = 2'd1;
  localparam logic [1:0] RK_NRET = 2'd2;

  // status word
  localparam int B_SIE  = 0;
  localparam int B_MIE  = 1;
  localparam int B_SPIE = 2;
  localparam int B_MPIE = 3;
  localparam int B_SPP  = 4;
  localparam int B_MPP  = 5;
  localparam int B_MPV  = 7;
  localparam int B_MPRV = 8;
  localparam int B_SDT  = 9;
  localparam int B_MDT  = 10;
  localparam int B_TSR  = 11;
  // hypervisor-status word
  localparam int B_SPV  = 0;
  localparam int B_VTSR = 1;
  // NMI-status word
  localparam int B_NMIE = 0;
  localparam int B_NPV  = 1;
  localparam int B_NPP  = 2;

  localparam logic [FC_W-1:0] FC_MISAL   = 5'd0;
  localparam logic [FC_W-1:0] FC_ACCESS  = 5'd1;
  localparam logic [FC_W-1:0] FC_ILLEGAL = 5'd2;
  localparam logic [FC_W-1:0] FC_VIRT    = 5'd22;

  // return lands in user, VS or VU
  function automatic logic sdt_drop(input logic [1:0] tgt, input logic pv);
    return (tgt == LVL_USER) || (pv && (tgt == LVL_SUPV || tgt == LVL_USER));
  endfunction

  // return lands in VU
  function automatic logic vs_sdt_drop(input logic [1:0] tgt, input logic pv);
    return pv && (tgt == LVL_USER);
  endfunction
endpackage

// File: rtl/tret_check.sv
`timescale 1ns/1ps
module tret_check
  import tret_pkg::*;
(
  input  logic [1:0]      kind,
  input  logic [1:0]      cur_priv,
  input  logic            cur_virt,
  input  logic            tsr,
  input  logic            vtsr,
  input  logic [1:0]      pc_low,
  input  logic [1:0]      tgt_priv,
  input  logic            cfg_cmp,
  input  logic            cfg_pmp_on,
  input  logic            cfg_pmp_empty,
  output logic            fault,
  output logic [FC_W-1:0] code
);
  logic misal;
  assign misal = !cfg_cmp && (pc_low != 2'b00);

  always_comb begin
    fault = 1'b0;
    code  = FC_MISAL;
    unique case (kind)
      RK_SRET: begin
        if (cur_priv == LVL_USER) begin
          fault = 1'b1; code = FC_ILLEGAL;
        end else if (misal) begin
          fault = 1'b1; code = FC_MISAL;
        end else if (tsr && cur_priv != LVL_MACH) begin
          fault = 1'b1; code = FC_ILLEGAL;
        end else if (cur_virt && vtsr) begin
          fault = 1'b1; code = FC_VIRT;
        end
      end
      RK_MRET, RK_NRET: begin
        if (cur_priv != LVL_MACH) begin
          fault = 1'b1; code = FC_ILLEGAL;
        end else if (misal) begin
          fault = 1'b1; code = FC_MISAL;
        end else if (cfg_pmp_on && cfg_pmp_empty && tgt_priv != LVL_MACH) begin
          fault = 1'b1; code = FC_ACCESS;
        end
      end
      default: begin
        fault = 1'b1; code = FC_ILLEGAL;
      end
    endcase
  end
endmodule

// File: rtl/tret_update.sv
`timescale 1ns/1ps
module tret_update
  import tret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]       kind,
  input  logic [1:0]       cur_priv,
  input  logic             cur_virt,
  input  logic [ST_W-1:0]  st_i,
  input  logic [HST_W-1:0] hst_i,
  input  logic [NST_W-1:0] nst_i,
  input  logic             vs_sdt_i,
  input  logic [XLEN-1:0]  sepc,
  input  logic [XLEN-1:0]  mepc,
  input  logic [XLEN-1:0]  nepc,
  input  logic             cfg_umode,
  input  logic             cfg_hyp,
  input  logic             cfg_sdbl,
  input  logic             cfg_mdbl,
  output logic [ST_W-1:0]  st_o,
  output logic [HST_W-1:0] hst_o,
  output logic [NST_W-1:0] nst_o,
  output logic             vs_sdt_o,
  output logic [1:0]       tgt_priv,
  output logic             tgt_virt,
  output logic [XLEN-1:0]  pc_o
);
  logic pv;

  always_comb begin
    st_o     = st_i;
    hst_o    = hst_i;
    nst_o    = nst_i;
    vs_sdt_o = vs_sdt_i;
    tgt_virt = cur_virt;
    pv       = 1'b0;
    unique case (kind)
      RK_SRET: begin
        tgt_priv     = {1'b0, st_i[B_SPP]};
        pc_o         = sepc;
        st_o[B_SIE]  = st_i[B_SPIE];
        st_o[B_SPIE] = 1'b1;
        st_o[B_SPP]  = 1'b0;
        st_o[B_MPRV] = 1'b0;
        if (cfg_sdbl) begin
          if (cfg_hyp && !cur_virt && hst_i[B_SPV] && !st_i[B_SPP])
            vs_sdt_o = 1'b0;
          st_o[B_SDT] = 1'b0;
        end
        if (cfg_mdbl && cur_priv == LVL_MACH) st_o[B_MDT] = 1'b0;
        if (cfg_hyp && !cur_virt) begin
          tgt_virt     = hst_i[B_SPV];
          hst_o[B_SPV] = 1'b0;
        end
      end
      RK_MRET: begin
        tgt_priv     = st_i[B_MPP +: 2];
        pc_o         = mepc;
        pv           = st_i[B_MPV] && (tgt_priv != LVL_MACH);
        tgt_virt     = pv;
        st_o[B_MIE]  = st_i[B_MPIE];
        st_o[B_MPIE] = 1'b1;
        st_o[B_MPP +: 2] = cfg_umode ? LVL_USER : LVL_MACH;
        st_o[B_MPV]  = 1'b0;
        if (cfg_sdbl && sdt_drop(tgt_priv, pv)) begin
          st_o[B_SDT] = 1'b0;
          if (vs_sdt_drop(tgt_priv, pv)) vs_sdt_o = 1'b0;
        end
        if (cfg_mdbl) st_o[B_MDT] = 1'b0;
        if (tgt_priv != LVL_MACH) st_o[B_MPRV] = 1'b0;
      end
      default: begin
        tgt_priv     = nst_i[B_NPP +: 2];
        pc_o         = nepc;
        pv           = nst_i[B_NPV] && (tgt_priv != LVL_MACH);
        tgt_virt     = pv;
        nst_o[B_NMIE] = 1'b1;
        if (tgt_priv != LVL_MACH) st_o[B_MPRV] = 1'b0;
        if (cfg_sdbl && sdt_drop(tgt_priv, pv)) begin
          st_o[B_SDT] = 1'b0;
          if (vs_sdt_drop(tgt_priv, pv)) vs_sdt_o = 1'b0;
        end
        if (cfg_mdbl && tgt_priv != LVL_MACH) st_o[B_MDT] = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/trap_return_unit.sv
`timescale 1ns/1ps
module trap_return_unit
  import tret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       cur_priv,
  input  logic             cur_virt,
  input  logic [ST_W-1:0]  st_in,
  input  logic [HST_W-1:0] hst_in,
  input  logic [NST_W-1:0] nst_in,
  input  logic             vs_sdt_in,
  input  logic [XLEN-1:0]  sepc_in,
  input  logic [XLEN-1:0]  mepc_in,
  input  logic [XLEN-1:0]  nepc_in,
  input  logic             cfg_cmp,
  input  logic             cfg_umode,
  input  logic             cfg_hyp,
  input  logic             cfg_sdbl,
  input  logic             cfg_mdbl,
  input  logic             cfg_pmp_on,
  input  logic             cfg_pmp_empty,
  output logic             done,
  output logic             fault,
  output logic [FC_W-1:0]  fault_code,
  output logic [ST_W-1:0]  st_out,
  output logic [HST_W-1:0] hst_out,
  output logic [NST_W-1:0] nst_out,
  output logic             vs_sdt_out,
  output logic [1:0]       new_priv,
  output logic             new_virt,
  output logic [XLEN-1:0]  ret_pc
);
  logic [ST_W-1:0]  nx_st;
  logic [HST_W-1:0] nx_hst;
  logic [NST_W-1:0] nx_nst;
  logic             nx_vs_sdt;
  logic [1:0]       nx_priv;
  logic             nx_virt;
  logic [XLEN-1:0]  nx_pc;
  logic             chk_fault;
  logic [FC_W-1:0]  chk_code;

  // named events for the checker
  logic ev_commit;
  logic ev_refuse;
  assign ev_commit = req_valid && !chk_fault;
  assign ev_refuse = req_valid && chk_fault;

  tret_update #(.XLEN(XLEN)) u_upd (
    .kind(req_kind), .cur_priv(cur_priv), .cur_virt(cur_virt),
    .st_i(st_in), .hst_i(hst_in), .nst_i(nst_in), .vs_sdt_i(vs_sdt_in),
    .sepc(sepc_in), .mepc(mepc_in), .nepc(nepc_in),
    .cfg_umode(cfg_umode), .cfg_hyp(cfg_hyp),
    .cfg_sdbl(cfg_sdbl), .cfg_mdbl(cfg_mdbl),
    .st_o(nx_st), .hst_o(nx_hst), .nst_o(nx_nst), .vs_sdt_o(nx_vs_sdt),
    .tgt_priv(nx_priv), .tgt_virt(nx_virt), .pc_o(nx_pc)
  );

  tret_check u_chk (
    .kind(req_kind), .cur_priv(cur_priv), .cur_virt(cur_virt),
    .tsr(st_in[B_TSR]), .vtsr(hst_in[B_VTSR]), .pc_low(nx_pc[1:0]),
    .tgt_priv(nx_priv), .cfg_cmp(cfg_cmp),
    .cfg_pmp_on(cfg_pmp_on), .cfg_pmp_empty(cfg_pmp_empty),
    .fault(chk_fault), .code(chk_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= FC_MISAL;
      st_out     <= '0;
      hst_out    <= '0;
      nst_out    <= '0;
      vs_sdt_out <= 1'b0;
      new_priv   <= LVL_MACH;
      new_virt   <= 1'b0;
      ret_pc     <= '0;
    end else begin
      done  <= req_valid;
      fault <= ev_refuse;
      if (ev_refuse) fault_code <= chk_code;
      if (ev_commit) begin
        st_out     <= nx_st;
        hst_out    <= nx_hst;
        nst_out    <= nx_nst;
        vs_sdt_out <= nx_vs_sdt;
        new_priv   <= nx_priv;
        new_virt   <= nx_virt;
        ret_pc     <= nx_pc;
      end
    end
  end
endmodule

// File: rtl/trap_return_unit_chk.sv
`timescale 1ns/1ps
module trap_return_unit_chk
  import tret_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic             cfg_cmp,
  input logic             done,
  input logic             fault,
  input logic [FC_W-1:0]  fault_code,
  input logic [ST_W-1:0]  st_out,
  input logic [HST_W-1:0] hst_out,
  input logic [NST_W-1:0] nst_out,
  input logic [1:0]       new_priv,
  input logic             ev_commit,
  input logic             ev_refuse
);
  // R11
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid));

  // R10
  refuse_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |=> (fault && $stable(st_out) && $stable(hst_out)
                   && $stable(nst_out) && $stable(new_priv)));

  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_code == FC_MISAL || fault_code == FC_ACCESS ||
                         fault_code == FC_ILLEGAL || fault_code == FC_VIRT));

  // R2
  misal_needs_no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_refuse && !cfg_cmp) or (ev_refuse && cfg_cmp) |=>
      (fault_code != FC_MISAL) || !$past(cfg_cmp));

  // R3
  sret_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_commit && req_kind == RK_SRET) |=> (st_out[B_SPIE] && !st_out[B_SPP]));

  // R5
  mret_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_commit && req_kind == RK_MRET) |=> (st_out[B_MPIE] && !st_out[B_MPV]));

  // R7
  nret_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_commit && req_kind == RK_NRET) |=> nst_out[B_NMIE]);
endmodule

bind trap_return_unit trap_return_unit_chk u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .cfg_cmp(cfg_cmp), .done(done), .fault(fault), .fault_code(fault_code),
  .st_out(st_out), .hst_out(hst_out), .nst_out(nst_out), .new_priv(new_priv),
  .ev_commit(ev_commit), .ev_refuse(ev_refuse)
);

// File: tb/trap_return_unit_tb.sv
`timescale 1ns/1ps
module trap_return_unit_tb;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [1:0] cur_priv = 2'd3;
  logic cur_virt = 1'b0;
  logic [11:0] st_in = '0;
  logic [3:0] hst_in = '0;
  logic [3:0] nst_in = '0;
  logic vs_sdt_in = 1'b0;
  logic [XLEN-1:0] sepc_in = 32'h1000;
  logic [XLEN-1:0] mepc_in = 32'h2000;
  logic [XLEN-1:0] nepc_in = 32'h3000;
  logic cfg_cmp = 1'b1, cfg_umode = 1'b1, cfg_hyp = 1'b1;
  logic cfg_sdbl = 1'b0, cfg_mdbl = 1'b0, cfg_pmp_on = 1'b0, cfg_pmp_empty = 1'b0;
  logic done, fault, vs_sdt_out, new_virt;
  logic [4:0] fault_code;
  logic [11:0] st_out;
  logic [3:0] hst_out, nst_out;
  logic [1:0] new_priv;
  logic [XLEN-1:0] ret_pc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trap_return_unit #(.XLEN(XLEN)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] k, input logic [1:0] p, input logic v);
    @(negedge clk);
    req_kind = k; cur_priv = p; cur_virt = v; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic defaults();
    st_in = '0; hst_in = '0; nst_in = '0; vs_sdt_in = 1'b0;
    cfg_cmp = 1'b1; cfg_umode = 1'b1; cfg_hyp = 1'b1;
    cfg_sdbl = 1'b0; cfg_mdbl = 1'b0; cfg_pmp_on = 1'b0; cfg_pmp_empty = 1'b0;
    sepc_in = 32'h1000; mepc_in = 32'h2000; nepc_in = 32'h3000;
  endtask

  task automatic t_reset();
    chk("R11 reset done", {31'd0, done}, 0);
    chk("R11 reset priv", {30'd0, new_priv}, 3);
    chk("R11 reset st", {20'd0, st_out}, 0);
    chk("R11 reset fault", {31'd0, fault}, 0);
  endtask

  task automatic t_sret_hs_to_vs();
    defaults();
    st_in = 12'h314; hst_in = 4'h1; vs_sdt_in = 1'b1; cfg_sdbl = 1'b1;
    fire(2'd0, 2'd1, 1'b0);
    chk("R11 done", {31'd0, done}, 1);
    chk("R3 st", {20'd0, st_out}, 32'h005);
    chk("R3 priv", {30'd0, new_priv}, 1);
    chk("R3 pc", ret_pc, 32'h1000);
    chk("R4 virt from SPV", {31'd0, new_virt}, 1);
    chk("R4 SPV cleared", {28'd0, hst_out}, 0);
    chk("R9 vs sdt kept", {31'd0, vs_sdt_out}, 1);
    @(negedge clk);
    chk("R11 done one cycle", {31'd0, done}, 0);
  endtask

  task automatic t_sret_faults();
    defaults();
    st_in = 12'h314;
    fire(2'd0, 2'd0, 1'b0);
    chk("R1 from user", {31'd0, fault}, 1);
    chk("R1 code", {27'd0, fault_code}, 2);
    chk("R10 st held", {20'd0, st_out}, 32'h005);
    chk("R10 priv held", {30'd0, new_priv}, 1);
    st_in = 12'h800;
    fire(2'd0, 2'd1, 1'b0);
    chk("R1 TSR", {27'd0, fault_code}, 2);
    st_in = 12'h000; hst_in = 4'h2;
    fire(2'd0, 2'd1, 1'b1);
    chk("R1 VTSR", {27'd0, fault_code}, 22);
    st_in = 12'h800; hst_in = 4'h2;
    fire(2'd0, 2'd1, 1'b1);
    chk("R1 TSR before VTSR", {27'd0, fault_code}, 2);
    fire(2'd3, 2'd3, 1'b0);
    chk("R1 reserved kind", {27'd0, fault_code}, 2);
  endtask

  task automatic t_misaligned();
    defaults();
    cfg_cmp = 1'b0; sepc_in = 32'h1002; st_in = 12'h800;
    fire(2'd0, 2'd1, 1'b0);
    chk("R2 misal before TSR", {27'd0, fault_code}, 0);
    chk("R2 fault", {31'd0, fault}, 1);
    cfg_cmp = 1'b1; st_in = 12'h000;
    fire(2'd0, 2'd1, 1'b0);
    chk("R2 ok with cmp", {31'd0, fault}, 0);
    chk("R2 pc", ret_pc, 32'h1002);
    cfg_cmp = 1'b0; mepc_in = 32'h2001;
    fire(2'd1, 2'd3, 1'b0);
    chk("R2 mret misal", {27'd0, fault_code}, 0);
  endtask

  task automatic t_sret_from_m_and_virt();
    defaults();
    st_in = 12'hC01; cfg_mdbl = 1'b1;
    fire(2'd0, 2'd3, 1'b0);
    chk("R1 TSR ok in M", {31'd0, fault}, 0);
    chk("R9 MDT cleared", {20'd0, st_out}, 32'h804);
    chk("R3 priv user", {30'd0, new_priv}, 0);
    defaults();
    hst_in = 4'h1; cfg_sdbl = 1'b1; vs_sdt_in = 1'b1; st_in = 12'h200;
    fire(2'd0, 2'd1, 1'b1);
    chk("R4 virt kept", {31'd0, new_virt}, 1);
    chk("R4 SPV kept", {28'd0, hst_out}, 1);
    chk("R9 SDT cleared", {20'd0, st_out}, 32'h004);
    chk("R9 vs sdt kept virt", {31'd0, vs_sdt_out}, 1);
    defaults();
    hst_in = 4'h1; cfg_sdbl = 1'b1; vs_sdt_in = 1'b1;
    fire(2'd0, 2'd1, 1'b0);
    chk("R9 HS to VU vs sdt", {31'd0, vs_sdt_out}, 0);
  endtask

  task automatic t_mret();
    defaults();
    st_in = 12'h788; cfg_sdbl = 1'b1; cfg_mdbl = 1'b1; vs_sdt_in = 1'b1;
    fire(2'd1, 2'd3, 1'b0);
    chk("R5 st", {20'd0, st_out}, 32'h00A);
    chk("R5 priv", {30'd0, new_priv}, 0);
    chk("R6 virt", {31'd0, new_virt}, 1);
    chk("R9 vs sdt VU", {31'd0, vs_sdt_out}, 0);
    chk("R5 pc", ret_pc, 32'h2000);
    defaults();
    st_in = 12'h1E2; cfg_umode = 1'b0;
    fire(2'd1, 2'd3, 1'b0);
    chk("R6 MPRV kept to M", {20'd0, st_out}, 32'h168);
    chk("R6 virt zero to M", {31'd0, new_virt}, 0);
    chk("R5 priv M", {30'd0, new_priv}, 3);
  endtask

  task automatic t_mret_faults();
    defaults();
    fire(2'd1, 2'd1, 1'b0);
    chk("R8 mret from S", {27'd0, fault_code}, 2);
    cfg_pmp_on = 1'b1; cfg_pmp_empty = 1'b1;
    fire(2'd1, 2'd3, 1'b0);
    chk("R8 pmp empty", {27'd0, fault_code}, 1);
    st_in = 12'h060;
    fire(2'd1, 2'd3, 1'b0);
    chk("R8 pmp empty to M ok", {31'd0, fault}, 0);
    fire(2'd2, 2'd0, 1'b0);
    chk("R8 nret from U", {27'd0, fault_code}, 2);
  endtask

  task automatic t_nret();
    defaults();
    nst_in = 4'h6; st_in = 12'h702; cfg_sdbl = 1'b1; cfg_mdbl = 1'b1; vs_sdt_in = 1'b1;
    fire(2'd2, 2'd3, 1'b0);
    chk("R7 st", {20'd0, st_out}, 32'h002);
    chk("R7 nst", {28'd0, nst_out}, 7);
    chk("R7 priv", {30'd0, new_priv}, 1);
    chk("R7 virt", {31'd0, new_virt}, 1);
    chk("R9 vs sdt VS kept", {31'd0, vs_sdt_out}, 1);
    chk("R7 pc", ret_pc, 32'h3000);
    defaults();
    nst_in = 4'hE; st_in = 12'h500; cfg_mdbl = 1'b1;
    fire(2'd2, 2'd3, 1'b0);
    chk("R7 to M keeps", {20'd0, st_out}, 32'h500);
    chk("R7 nst to M", {28'd0, nst_out}, 32'hF);
    chk("R7 virt forced 0", {31'd0, new_virt}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sret_hs_to_vs();
    t_sret_faults();
    t_misaligned();
    t_sret_from_m_and_virt();
    t_mret();
    t_mret_faults();
    t_nret();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule